// File: doc/BRIEF.md
# NAND Page Column Pointer

This block holds the starting column for serial transfers into and out of a 528-byte page register inside a NAND memory model. The address phase supplies only one column byte. The missing upper bits come from an area selection that the last pointer command chose. Three command codes pick the area:

| Code | Area | Columns |
|------|------|---------|
| 00h | lower main half | 0..255 |
| 01h | upper main half | 256..511 |
| 50h | spare region | 512..527 |

When the column byte arrives, the block adds it to the base of the selected area and produces an absolute column index. Each data strobe then moves the index forward by one. The index stops at the last column of the page and raises an end-of-page flag there.

The lower half is the power-up default. A selection of the upper half is good for one operation only: when the operation-complete pulse arrives, the pointer goes back to the lower half. A selection of the spare region stays in place until 00h or 01h is written. Any other command code has no effect on the pointer. A later address cycle with no new pointer command reuses the area that is currently selected.

Top module: `nand_colptr`

## Requirements
- R1: Reset behaviour. After reset `col` is 0, `area` is 0 (lower half) and `eop` is 0.
- R2: Command 00h sets `area` to 0. A following address cycle with byte v loads `col` = v.
- R3: Command 01h sets `area` to 1. A following address cycle with byte v loads `col` = 256 + v.
- R4: Command 50h sets `area` to 2. A following address cycle with byte v loads `col` = 512 + (v mod 16), so the upper four bits of the byte are ignored.
- R5: Increment. With `addr_we` low, each cycle with `data_stb` high raises `col` by one, provided `col` is below 527. The count crosses the area boundaries without interruption, for example 511 to 512.
- R6: End of page. `eop` is 1 exactly when `col` is 527, and further strobes leave `col` at 527.
- R7: With `area` at 1, an `op_done` pulse with no command in the same cycle returns `area` to 0. With `area` at 0, `op_done` leaves it at 0, so a later address cycle still uses base 0.
- R8: With `area` at 2, `op_done` leaves `area` at 2 until a 00h or 01h command is written.
- R9: A command code other than 00h, 01h and 50h leaves both `area` and `col` unchanged.
- R10: `area` never takes the value 3. `col` and `area` update on the clock edge that follows the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command cycle strobe |
| cmd | input | 8 | Command code |
| addr_we | input | 1 | Column address cycle strobe |
| addr | input | 8 | Column address byte |
| data_stb | input | 1 | Data read/write strobe |
| op_done | input | 1 | Operation-complete pulse |
| col | output | 10 | Absolute column index |
| area | output | 2 | Selected area: 0 lower, 1 upper, 2 spare |
| eop | output | 1 | Column is at the last page column |

## Verification
The bench sweeps every column byte under each of the three pointer commands.

- Losing the spare masking would send `col` past 527 when the byte's upper nibble is nonzero.
- A wrong base would misplace the whole upper half.

It walks each area to the page end and keeps strobing there:

- Missing saturation would wrap `col` to 0 or overflow it.
- A late `eop` would show up one column off.

It also pulses `op_done` after each selection and writes unrelated command codes:

- A sticky upper-half selection would leave the next address at 256 or above.
- A spare selection that wrongly reverts would lose the spare base.
- Decoding too loosely would let a foreign code move the pointer.

// File: rtl/nand_colptr.sv
module nand_colptr #(
  parameter int PAGE_COLS  = 528,
  parameter int AREA_SPAN  = 256,
  parameter int SPARE_BITS = 4,
  parameter int ABITS      = 8,
  parameter int CW         = $clog2(PAGE_COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd,
  input  logic          addr_we,
  input  logic [ABITS-1:0] addr,
  input  logic          data_stb,
  input  logic          op_done,
  output logic [CW-1:0] col,
  output logic [1:0]    area,
  output logic          eop
);
  localparam int SPAN_SH = $clog2(AREA_SPAN);
  localparam logic [CW-1:0] LAST = CW'(PAGE_COLS - 1);
  localparam logic [7:0] CMD_LO = 8'h00;
  localparam logic [7:0] CMD_HI = 8'h01;
  localparam logic [7:0] CMD_SP = 8'h50;
  localparam logic [1:0] AR_LO = 2'd0;
  localparam logic [1:0] AR_HI = 2'd1;
  localparam logic [1:0] AR_SP = 2'd2;

  logic [1:0]    area_q;
  logic [CW-1:0] col_q;
  logic [CW-1:0] base;
  logic [CW-1:0] offs;

  assign base = CW'(area_q) << SPAN_SH;
  assign offs = (area_q == AR_SP) ? CW'(addr[SPARE_BITS-1:0]) : CW'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_q <= AR_LO;
    end else if (cmd_we) begin
      case (cmd)
        CMD_LO:  area_q <= AR_LO;
        CMD_HI:  area_q <= AR_HI;
        CMD_SP:  area_q <= AR_SP;
        default: area_q <= area_q;
      endcase
    end else if (op_done && area_q == AR_HI) begin
      area_q <= AR_LO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      col_q <= '0;
    else if (addr_we)
      col_q <= base + offs;
    else if (data_stb && col_q != LAST)
      col_q <= col_q + CW'(1);
  end

  assign col  = col_q;
  assign area = area_q;
  assign eop  = (col_q == LAST);
endmodule

module nand_colptr_chk #(
  parameter int PAGE_COLS  = 528,
  parameter int AREA_SPAN  = 256,
  parameter int SPARE_BITS = 4,
  parameter int ABITS      = 8,
  parameter int CW         = $clog2(PAGE_COLS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    cmd,
  input logic          addr_we,
  input logic [ABITS-1:0] addr,
  input logic          data_stb,
  input logic          op_done,
  input logic [CW-1:0] col,
  input logic [1:0]    area,
  input logic          eop
);
  localparam logic [CW-1:0] LAST = CW'(PAGE_COLS - 1);
  localparam logic [CW-1:0] SP_BASE = CW'(2 * AREA_SPAN);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> col == '0 && area == 2'd0);

  p_load_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we && area == 2'd0 |=> col == CW'($past(addr)));

  p_load_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we && area == 2'd2 |=> col == SP_BASE + CW'($past(addr[SPARE_BITS-1:0])));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb && !addr_we && !eop |=> col == $past(col) + CW'(1));

  p_hold_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb && !addr_we && eop |=> eop && $stable(col));

  p_revert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !cmd_we && area == 2'd1 |=> area == 2'd0);

  p_spare_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !cmd_we && area == 2'd2 |=> area == 2'd2);

  p_area_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    area != 2'd3 && col <= LAST);
endmodule

bind nand_colptr nand_colptr_chk #(
  .PAGE_COLS(PAGE_COLS), .AREA_SPAN(AREA_SPAN), .SPARE_BITS(SPARE_BITS),
  .ABITS(ABITS), .CW(CW)
) u_chk (.*);

// File: tb/nand_colptr_bench.sv
module nand_colptr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       addr_we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       data_stb = 1'b0;
  logic       op_done = 1'b0;
  logic [9:0] col;
  logic [1:0] area;
  logic       eop;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nand_colptr u_nand_colptr (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
    .addr_we(addr_we), .addr(addr), .data_stb(data_stb),
    .op_done(op_done), .col(col), .area(area), .eop(eop)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic do_addr(input logic [7:0] v);
    @(negedge clk); addr_we = 1'b1; addr = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic do_stb();
    @(negedge clk); data_stb = 1'b1;
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  function automatic logic [7:0] code_of(input int a);
    return (a == 0) ? 8'h00 : (a == 1) ? 8'h01 : 8'h50;
  endfunction

  function automatic int exp_col(input int a, input int v);
    return a * 256 + ((a == 2) ? (v % 16) : v);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 col", col, 0);
    chk("R1 area", area, 0);
    chk("R1 eop", eop, 0);

    for (int a = 0; a < 3; a++) begin
      for (int v = 0; v < 256; v++) begin
        int e;
        string tag;
        tag = (a == 0) ? "R2" : (a == 1) ? "R3" : "R4";
        do_cmd(code_of(a));
        chk({tag, " area"}, area, a);
        do_addr(v[7:0]);
        e = exp_col(a, v);
        chk({tag, " col"}, col, e);
        do_stb();
        e = (e < 527) ? e + 1 : 527;
        chk("R5 step", col, e);
        chk("R6 eop", eop, (e == 527) ? 1 : 0);
      end
    end

    for (int a = 0; a < 3; a++) begin
      do_cmd(code_of(a));
      do_addr(8'h00);
      for (int k = exp_col(a, 0); k < 527; k++) begin
        chk("R6 eop low", eop, 0);
        do_stb();
        chk("R5 walk", col, k + 1);
      end
      chk("R6 eop high", eop, 1);
      repeat (3) do_stb();
      chk("R6 saturate", col, 527);
      chk("R6 eop held", eop, 1);
    end

    do_cmd(8'h01);
    do_done();
    chk("R7 revert", area, 0);
    do_addr(8'd77);
    chk("R7 reuse base", col, 77);
    do_done();
    chk("R7 stay lo", area, 0);
    do_addr(8'd9);
    chk("R7 reuse again", col, 9);

    do_cmd(8'h50);
    do_done();
    chk("R8 keep spare", area, 2);
    do_addr(8'hF3);
    chk("R8 spare base", col, 515);
    do_done();
    do_addr(8'h21);
    chk("R8 still spare", col, 513);

    do_addr(8'h05);
    begin
      logic [7:0] junk [4] = '{8'h80, 8'h60, 8'hFF, 8'h02};
      for (int i = 0; i < 4; i++) begin
        do_cmd(junk[i]);
        chk("R9 area", area, 2);
        chk("R9 col", col, 517);
      end
    end
    do_cmd(8'h00);
    chk("R8 leave spare", area, 0);
    chk("R10 area legal", (area != 2'd3) ? 1 : 0, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule